// File: doc/BRIEF.md
# SMRAM-at-SMBASE lock negotiation register

This block is one 8-bit configuration register of a host bridge. Through it, boot firmware learns whether a protected SMRAM window at the default SMBASE area exists, and then closes that window for good. The firmware first writes a query value. If the feature is present, the register answers with an acknowledge code, and from then on only the lock bit can be written. Setting that bit locks the register. While it is locked, two enables are driven: one makes non-SMM accesses to the window return all-ones, the other maps RAM at that address for SMM accesses. The window covers 128 KB at 0x30000. The address routing that the enables steer lies outside this block.

A strap input tells the block whether the feature is present. With the strap clear, the register is plain read/write storage with no side effects. With the strap set, any value written before the handshake is thrown away. Only reset clears the lock.

Top module: `smb_lock_reg`

## Requirements
- R1: After reset the register reads 0x00, the write mask is 0xFF, and both window enables are low.
- R2: With the strap clear, a write stores the written byte, which reads back on the next cycle. The write mask stays 0xFF and both enables stay low.
- R3: With the strap set and no handshake done (mask 0xFF), a write of any value other than 0xFF is discarded and the register reads 0x00.
- R4: With the strap set and mask 0xFF, writing the query value 0xFF makes the register read the acknowledge code 0x01 and sets the write mask to 0x02 (the lock bit, bit 1).
- R5: After the handshake, a write with bit 1 clear leaves the register at 0x01, whatever the other bits hold.
- R6: After the handshake, a write with bit 1 set locks the register. It then reads exactly 0x02 and the write mask becomes 0x00.
- R7: While locked, no write changes the register value, the mask or the enables, including writes of 0xFF and 0x00.
- R8: The non-SMM blackhole enable and the SMM window enable are both high while locked and both low otherwise.
- R9: Only reset clears the lock. After reset the block is back in its R1 state and can negotiate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Feature-present strap, static outside reset |
| cfg_we_i | input | 1 | Config write strobe for this byte |
| cfg_wdata_i | input | 8 | Config write data |
| cfg_rdata_o | output | 8 | Current register value |
| cfg_wmask_o | output | 8 | Current per-bit write mask |
| blackhole_en_o | output | 1 | Non-SMM accesses to the window read all-ones |
| smm_window_en_o | output | 1 | SMM accesses to the window map RAM |

## Verification
The internal mode (open, armed, locked) can be seen directly on the mask port. The register value and both enables are registered, so a wrong mode decision shows up on cfg_rdata_o, cfg_wmask_o or the enables in the cycle that follows the offending write. A stuck or skipped mode shows up either as a discarded value that was kept, or as a lock that a later write or 0xFF query undoes. The bench therefore follows every transition with writes that a correct design must ignore, and reads all four outputs one cycle after each write.

// File: rtl/smb_lock_pkg.sv
package smb_lock_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd0,
    MODE_ARMED  = 2'd1,
    MODE_LOCKED = 2'd2
  } smb_mode_e;
endpackage

// File: rtl/smb_write_decode.sv
module smb_write_decode
  import smb_lock_pkg::*;
#(
  parameter int          REG_W     = 8,
  parameter logic [REG_W-1:0] QUERY_VAL = '1,
  parameter logic [REG_W-1:0] ACK_VAL   = 1,
  parameter int          LOCK_BIT  = 1
) (
  input  smb_mode_e        mode_i,
  input  logic [REG_W-1:0] cur_val_i,
  input  logic [REG_W-1:0] mask_i,
  input  logic             strap_en_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output smb_mode_e        nxt_mode_o,
  output logic [REG_W-1:0] nxt_val_o
);
  localparam logic [REG_W-1:0] LockVal = REG_W'(1) << LOCK_BIT;

  logic [REG_W-1:0] merged;
  assign merged = (cur_val_i & ~mask_i) | (wdata_i & mask_i);

  always_comb begin
    nxt_mode_o = mode_i;
    nxt_val_o  = cur_val_i;
    if (we_i) begin
      if (!strap_en_i) begin
        nxt_val_o = merged;
      end else begin
        unique case (mode_i)
          MODE_OPEN: begin
            if (merged == QUERY_VAL) begin
              nxt_val_o  = ACK_VAL;
              nxt_mode_o = MODE_ARMED;
            end else begin
              nxt_val_o = '0;  // pre-handshake writes are dropped
            end
          end
          MODE_ARMED: begin
            if (merged[LOCK_BIT]) begin
              nxt_val_o  = LockVal;
              nxt_mode_o = MODE_LOCKED;
            end else begin
              nxt_val_o = merged;
            end
          end
          default: nxt_val_o = merged;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_state_regs.sv
module smb_state_regs
  import smb_lock_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smb_mode_e        nxt_mode_i,
  input  logic [REG_W-1:0] nxt_val_i,
  output smb_mode_e        mode_o,
  output logic [REG_W-1:0] val_o,
  output logic             locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_OPEN;
      val_o    <= '0;
      locked_o <= 1'b0;
    end else begin
      mode_o   <= nxt_mode_i;
      val_o    <= nxt_val_i;
      locked_o <= (nxt_mode_i == MODE_LOCKED);
    end
  end
endmodule

// File: rtl/smb_lock_reg.sv
module smb_lock_reg
  import smb_lock_pkg::*;
#(
  parameter int               REG_W     = 8,
  parameter logic [REG_W-1:0] QUERY_VAL = 8'hFF,
  parameter logic [REG_W-1:0] ACK_VAL   = 8'h01,
  parameter int               LOCK_BIT  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_en_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic [REG_W-1:0] cfg_wmask_o,
  output logic             blackhole_en_o,
  output logic             smm_window_en_o
);
  localparam logic [REG_W-1:0] LockMask = REG_W'(1) << LOCK_BIT;

  smb_mode_e        mode_q, mode_d;
  logic [REG_W-1:0] val_q, val_d;
  logic             locked_q;

  always_comb begin
    unique case (mode_q)
      MODE_OPEN:  cfg_wmask_o = '1;
      MODE_ARMED: cfg_wmask_o = LockMask;
      default:    cfg_wmask_o = '0;
    endcase
  end

  smb_write_decode #(
    .REG_W(REG_W), .QUERY_VAL(QUERY_VAL), .ACK_VAL(ACK_VAL), .LOCK_BIT(LOCK_BIT)
  ) u_dec (
    .mode_i(mode_q), .cur_val_i(val_q), .mask_i(cfg_wmask_o),
    .strap_en_i(strap_en_i), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .nxt_mode_o(mode_d), .nxt_val_o(val_d)
  );

  smb_state_regs #(.REG_W(REG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nxt_mode_i(mode_d), .nxt_val_i(val_d),
    .mode_o(mode_q), .val_o(val_q), .locked_o(locked_q)
  );

  assign cfg_rdata_o     = val_q;
  assign blackhole_en_o  = locked_q;
  assign smm_window_en_o = locked_q;
endmodule

// File: rtl/smb_lock_chk.sv
module smb_lock_chk #(
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strap_en_i,
  input logic             cfg_we_i,
  input logic [REG_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0] cfg_rdata_o,
  input logic [REG_W-1:0] cfg_wmask_o,
  input logic             blackhole_en_o,
  input logic             smm_window_en_o
);
  // R2
  strap_clear_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_en_i && cfg_we_i && cfg_wmask_o == 8'hFF |=>
      cfg_rdata_o == $past(cfg_wdata_i) && cfg_wmask_o == 8'hFF && !blackhole_en_o);
  // R3
  pre_handshake_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_en_i && cfg_we_i && cfg_wmask_o == 8'hFF && cfg_wdata_i != 8'hFF |=>
      cfg_rdata_o == 8'h00 && cfg_wmask_o == 8'hFF);
  // R4
  query_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_en_i && cfg_we_i && cfg_wmask_o == 8'hFF && cfg_wdata_i == 8'hFF |=>
      cfg_rdata_o == 8'h01 && cfg_wmask_o == 8'h02);
  // R6
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wmask_o == 8'h02 && cfg_wdata_i[1] |=>
      cfg_rdata_o == 8'h02 && cfg_wmask_o == 8'h00);
  // R7
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blackhole_en_o |=> blackhole_en_o && $stable(cfg_rdata_o) && $stable(cfg_wmask_o));
  // R8
  enables_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blackhole_en_o == smm_window_en_o);
  // R8
  enable_means_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blackhole_en_o |-> cfg_rdata_o == 8'h02 && cfg_wmask_o == 8'h00);
endmodule

bind smb_lock_reg smb_lock_chk #(.REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strap_en_i(strap_en_i),
  .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .cfg_wmask_o(cfg_wmask_o), .blackhole_en_o(blackhole_en_o),
  .smm_window_en_o(smm_window_en_o)
);

// File: tb/sim_smb_lock_reg.sv
`timescale 1ns/1ps
module sim_smb_lock_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strap_en_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_rdata_o, cfg_wmask_o;
  logic       blackhole_en_o, smm_window_en_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  smb_lock_reg u0 (.*);

  task automatic check(input string req, input logic [7:0] rd, input logic [7:0] mk,
                       input logic en);
    checks++;
    if (cfg_rdata_o !== rd || cfg_wmask_o !== mk ||
        blackhole_en_o !== en || smm_window_en_o !== en) begin
      errors++;
      $display("FAIL %s: rdata=%h mask=%h bh=%b win=%b expected rdata=%h mask=%h en=%b",
               req, cfg_rdata_o, cfg_wmask_o, blackhole_en_o, smm_window_en_o, rd, mk, en);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0; strap_en_i = strap;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    check("R1", 8'h00, 8'hFF, 1'b0);
  endtask

  task automatic t_strap_clear();
    do_reset(1'b0);
    wr(8'h5A); check("R2", 8'h5A, 8'hFF, 1'b0);
    wr(8'hFF); check("R2", 8'hFF, 8'hFF, 1'b0);
    wr(8'h02); check("R2", 8'h02, 8'hFF, 1'b0);
  endtask

  task automatic t_discard();
    do_reset(1'b1);
    wr(8'h02); check("R3", 8'h00, 8'hFF, 1'b0);
    wr(8'hFE); check("R3", 8'h00, 8'hFF, 1'b0);
    wr(8'h01); check("R3", 8'h00, 8'hFF, 1'b0);
  endtask

  task automatic t_handshake_lock();
    do_reset(1'b1);
    wr(8'hFF); check("R4", 8'h01, 8'h02, 1'b0);
    wr(8'hFD); check("R5", 8'h01, 8'h02, 1'b0);
    wr(8'h00); check("R5", 8'h01, 8'h02, 1'b0);
    wr(8'hFF); check("R6", 8'h02, 8'h00, 1'b1);
    wr(8'hFF); check("R7", 8'h02, 8'h00, 1'b1);
    wr(8'h00); check("R7", 8'h02, 8'h00, 1'b1);
    wr(8'h01); check("R8", 8'h02, 8'h00, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R9", 8'h02, 8'h00, 1'b1);
  endtask

  task automatic t_relock_after_reset();
    do_reset(1'b1);
    check("R9", 8'h00, 8'hFF, 1'b0);
    wr(8'hFF); check("R4", 8'h01, 8'h02, 1'b0);
    wr(8'h02); check("R6", 8'h02, 8'h00, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_strap_clear();
    t_discard();
    t_handshake_lock();
    t_relock_after_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule